// File: doc/BRIEF.md
# SDRAM Timing-Select Command Controller

This block drives a single 32-bit-wide SDRAM one access at a time with a closed-page policy. Every access opens a row, issues one column command, raises a one-cycle transfer acknowledge and then closes all banks. The spacing between commands comes from a small control register. Each timing field there is a single bit that picks between a short and a long nanosecond limit. The limits are turned into clock counts at elaboration from the clock-period parameter, rounding up.

Software brings the memory up in three steps. It writes the init bit to start a PRECHARGE ALL, and that bit clears itself once the command's recovery time has run out. It then waits for several refresh periods. Finally it arms the mode-load bit, so that the next ordinary access goes out as LOAD MODE REGISTER. The mode value for that command comes from the access's word address, which is the byte address shifted right by two. A refresh timer raises a refresh request at a fixed interval. The request wins over a new access but never cuts into one that has already started.

The access request uses valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While `req_ready` is low, the requester must hold `req_valid`, `req_write` and `req_addr` steady. The control register pins and the acknowledge are plain signals.

Top module: `sdram_cfg_ctrl`

## Requirements
- R1: During reset and right after it, `sd_cmd` is NOP (0), `xfer_ack` is 0, `cfg_rdata` is 0 and `req_ready` is 1.
- R2: An accepted ordinary access issues ACTIVE (1) with the row field `req_addr[21:10]` on `sd_addr`. READ (2) or WRITE (3) follows tRCD cycles later with the column `req_addr[9:2]` zero-extended. tRCD is ceil(25 ns / period) when control bit 1 is 0, and ceil(50 ns / period) when it is 1.
- R3: `xfer_ack` is high for exactly one cycle, CL cycles after the column command. CL is 2 when control bit 0 is 0 and 3 when it is 1.
- R4: A PRECHARGE ALL (4, with `sd_addr` bit 10 set and all other bits 0) closes every access. For a read it comes one cycle after the acknowledge. For a write it comes tWR cycles after the acknowledge, where tWR is 25 ns when control bit 2 is 0 and 50 ns when it is 1, rounded up to cycles.
- R5: After any PRECHARGE ALL, only NOP is issued for tRP cycles (25 or 50 ns by control bit 3). The controller can issue again one cycle after tRP has run out.
- R6: Every REF_INTERVAL cycles a refresh becomes pending. A pending refresh is issued as AUTO REFRESH (5) before any new access, but never during an access. NOP follows for tRC cycles (75 or 100 ns by control bit 4), and the controller is idle again at the end of tRC.
- R7: Writing 1 to control bit 6 starts a PRECHARGE ALL as soon as the controller is idle. Bit 6 reads 1 from that write until tRP after the precharge, then reads 0. Writing 0 to bit 6 has no effect.
- R8: With control bit 5 set, the next accepted access issues LOAD MODE REGISTER (6) with `sd_addr` = `req_addr[13:2]` and no ACTIVE. Bit 5 clears on that edge, and the acknowledge follows MRD_CYC cycles later.
- R9: `req_ready` is high only while the controller is idle with no init or refresh pending. It drops on the edge that accepts a request and stays low until that operation has finished.
- R10: `cfg_rdata` bits 4:0 return the last timing bits written: bit 0 CAS latency, bit 1 RAS-to-CAS, bit 2 write recovery, bit 3 precharge, bit 4 refresh-to-active. Bit 5 is the mode-load arm and bit 6 the init flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control register write value |
| cfg_rdata | output | 7 | Control register read value |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W-2 | Word address (byte address bits ADDR_W-1 down to 2) |
| sd_cmd | output | 3 | SDRAM command code |
| sd_addr | output | ROW_W | SDRAM address lines |
| xfer_ack | output | 1 | Transfer acknowledge strobe |

## Verification
Reads and writes run under all-short, all-long and mixed timing selections. A timing bit that is wired to the wrong field, or that rounds the wrong way, moves a command by at least one cycle. A long run of back-to-back requests with `req_valid` held high makes the refresh timer expire both while an access is in flight and while requests are waiting, which separates "refresh first" from "refresh interrupts". An init request followed by a write of 0 to the init bit, and an armed access whose address carries a real mode word, exercise the two self-clearing flags and the address shift.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CNT_W = 8;
  localparam int CFG_W = 7;
  localparam int AP_BIT = 10;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_LMR = 3'd6
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ACT, S_COL, S_REC, S_PRE, S_REF, S_LMR
  } seq_st_e;

  typedef struct packed {
    cnt_t cl;
    cnt_t rcd;
    cnt_t wr;
    cnt_t rp;
    cnt_t rc;
  } sdc_times_t;

  // Nanosecond limit to whole clocks, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    int c;
    c = (ns * 1000 + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/sdc_timing.sv
module sdc_timing
  import sdc_pkg::*;
#(
  parameter int CLK_PS = 10000
) (
  input  logic [4:0]  sel,
  output sdc_times_t  times
);
  localparam int RCD_S = ns_to_cyc(25, CLK_PS);
  localparam int RCD_L = ns_to_cyc(50, CLK_PS);
  localparam int WR_S  = ns_to_cyc(25, CLK_PS);
  localparam int WR_L  = ns_to_cyc(50, CLK_PS);
  localparam int RP_S  = ns_to_cyc(25, CLK_PS);
  localparam int RP_L  = ns_to_cyc(50, CLK_PS);
  localparam int RC_S  = ns_to_cyc(75, CLK_PS);
  localparam int RC_L  = ns_to_cyc(100, CLK_PS);

  always_comb begin
    times.cl  = sel[0] ? cnt_t'(3)     : cnt_t'(2);
    times.rcd = sel[1] ? cnt_t'(RCD_L) : cnt_t'(RCD_S);
    times.wr  = sel[2] ? cnt_t'(WR_L)  : cnt_t'(WR_S);
    times.rp  = sel[3] ? cnt_t'(RP_L)  : cnt_t'(RP_S);
    times.rc  = sel[4] ? cnt_t'(RC_L)  : cnt_t'(RC_S);
  end
endmodule

// File: rtl/sdc_refresh.sv
module sdc_refresh #(
  parameter int REF_INTERVAL = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic taken,
  output logic pend
);
  localparam int RW = $clog2(REF_INTERVAL + 1);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= RW'(REF_INTERVAL - 1);
      pend <= 1'b0;
    end else begin
      if (taken) pend <= 1'b0;
      if (cnt == '0) begin
        pend <= 1'b1;
        cnt  <= RW'(REF_INTERVAL - 1);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdc_cfg_regs.sv
module sdc_cfg_regs
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             lmr_issue,
  input  logic             init_done,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (init_done) q[6] <= 1'b0;
      if (lmr_issue) q[5] <= 1'b0;
      if (we) begin
        q[4:0] <= wdata[4:0];
        q[5]   <= wdata[5];
        if (wdata[6] && !q[6]) q[6] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdc_seq.sv
module sdc_seq
  import sdc_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int MRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sdc_times_t        times,
  input  logic              arm,
  input  logic              init_pend,
  input  logic              ref_pend,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:2] req_addr,
  output logic              req_ready,
  output logic [2:0]        cmd,
  output logic [ROW_W-1:0]  addr,
  output logic              ack,
  output logic              ref_take,
  output logic              lmr_issue,
  output logic              init_done,
  output logic              init_run
);
  seq_st_e          st;
  cnt_t             cnt;
  logic             wr_q;
  logic [COL_W-1:0] col_q;
  sd_cmd_e          cmd_q;
  logic             go_init, go_acc, in_idle;

  assign in_idle   = (st == S_IDLE);
  assign go_init   = in_idle && init_pend;
  assign ref_take  = in_idle && !init_pend && ref_pend;
  assign req_ready = in_idle && !init_pend && !ref_pend;
  assign go_acc    = req_valid && req_ready;
  assign lmr_issue = go_acc && arm;
  assign init_done = (st == S_PRE) && (cnt == '0) && init_run;
  assign cmd       = cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      wr_q     <= 1'b0;
      col_q    <= '0;
      cmd_q    <= CMD_NOP;
      addr     <= '0;
      ack      <= 1'b0;
      init_run <= 1'b0;
    end else begin
      cmd_q <= CMD_NOP;
      addr  <= '0;
      ack   <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (go_init) begin
            cmd_q        <= CMD_PRE;
            addr[AP_BIT] <= 1'b1;
            cnt          <= times.rp - 1'b1;
            init_run     <= 1'b1;
            st           <= S_PRE;
          end else if (ref_take) begin
            cmd_q <= CMD_REF;
            cnt   <= times.rc - 1'b1;
            st    <= S_REF;
          end else if (go_acc) begin
            if (arm) begin
              cmd_q <= CMD_LMR;
              addr  <= req_addr[2 +: ROW_W];
              cnt   <= cnt_t'(MRD_CYC - 1);
              st    <= S_LMR;
            end else begin
              cmd_q <= CMD_ACT;
              addr  <= req_addr[2+COL_W +: ROW_W];
              wr_q  <= req_write;
              col_q <= req_addr[2 +: COL_W];
              cnt   <= times.rcd - 1'b1;
              st    <= S_ACT;
            end
          end
        end
        S_ACT: begin
          if (cnt == '0) begin
            cmd_q <= wr_q ? CMD_WR : CMD_RD;
            addr  <= ROW_W'(col_q);
            cnt   <= times.cl - 1'b1;
            st    <= S_COL;
          end else cnt <= cnt - 1'b1;
        end
        S_COL: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            cnt <= wr_q ? (times.wr - 1'b1) : '0;
            st  <= S_REC;
          end else cnt <= cnt - 1'b1;
        end
        S_REC: begin
          if (cnt == '0) begin
            cmd_q        <= CMD_PRE;
            addr[AP_BIT] <= 1'b1;
            cnt          <= times.rp - 1'b1;
            st           <= S_PRE;
          end else cnt <= cnt - 1'b1;
        end
        S_PRE: begin
          if (cnt == '0) begin
            init_run <= 1'b0;
            st       <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        S_REF: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        S_LMR: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            st  <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cfg_ctrl.sv
module sdram_cfg_ctrl
  import sdc_pkg::*;
#(
  parameter int CLK_PS       = 10000,
  parameter int REF_INTERVAL = 150,
  parameter int MRD_CYC      = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int ADDR_W       = 2 + COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_wdata,
  output logic [6:0]        cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:2] req_addr,
  output logic [2:0]        sd_cmd,
  output logic [ROW_W-1:0]  sd_addr,
  output logic              xfer_ack
);
  logic [CFG_W-1:0] cfg_q;
  sdc_times_t       times;
  logic             ref_pend, ref_take, lmr_issue, init_done, init_run;

  sdc_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .lmr_issue(lmr_issue), .init_done(init_done), .q(cfg_q)
  );

  sdc_timing #(.CLK_PS(CLK_PS)) u_timing (
    .sel(cfg_q[4:0]), .times(times)
  );

  sdc_refresh #(.REF_INTERVAL(REF_INTERVAL)) u_refresh (
    .clk(clk), .rst_n(rst_n), .taken(ref_take), .pend(ref_pend)
  );

  sdc_seq #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .MRD_CYC(MRD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .times(times), .arm(cfg_q[5]),
    .init_pend(cfg_q[6] && !init_run), .ref_pend(ref_pend),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .cmd(sd_cmd), .addr(sd_addr), .ack(xfer_ack),
    .ref_take(ref_take), .lmr_issue(lmr_issue), .init_done(init_done),
    .init_run(init_run)
  );

  assign cfg_rdata = cfg_q;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int CLK_PS = 10000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sd_cmd,
  input logic       ack,
  input logic       req_ready,
  input logic       cfg_we,
  input logic [6:0] cfg_rdata
);
  // R3: the acknowledge is a single-cycle strobe
  p_ack_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R3: no command goes out in the acknowledge cycle
  p_ack_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> sd_cmd == 3'd0);

  // R7: no request is accepted while init is in progress
  p_init_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |-> !req_ready);

  // R8: the arm bit is gone once LOAD MODE REGISTER is out
  p_arm_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == 3'd6 && !$past(cfg_we)) |-> !cfg_rdata[5]);

  // R9: ready only in idle cycles with no command on the bus
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sd_cmd == 3'd0);

  if (sdc_pkg::ns_to_cyc(25, CLK_PS) > 1) begin : g_gap
    // R2: ACTIVE is never followed directly by another command
    p_act_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sd_cmd == 3'd1 |=> sd_cmd == 3'd0);
  end
endmodule

bind sdram_cfg_ctrl sdc_checker #(.CLK_PS(CLK_PS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cmd(sd_cmd), .ack(xfer_ack),
  .req_ready(req_ready), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata)
);

// File: tb/tb_sdram_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_cfg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = 10000;
  localparam int REF_INT    = 150;
  localparam int MRD        = 2;
  localparam int ROW_W      = 12;
  localparam int COL_W      = 8;
  localparam int ADDR_W     = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [6:0] cfg_wdata = '0;
  logic [6:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [ADDR_W-1:2] req_addr = '0;
  logic [2:0] sd_cmd;
  logic [ROW_W-1:0] sd_addr;
  logic xfer_ack;

  sdram_cfg_ctrl #(.CLK_PS(CLK_PS), .REF_INTERVAL(REF_INT), .MRD_CYC(MRD),
                   .ROW_W(ROW_W), .COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .sd_cmd(sd_cmd),
    .sd_addr(sd_addr), .xfer_ack(xfer_ack)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int cyc(input int ns);
    int c;
    c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // Behavioural reference: a timeline of expected events keyed by edge number.
  int n, idle_edge, ref_ctr, init_clear;
  bit ref_pend, init_pend, busy, arm, busy_b;
  bit [4:0] tim;
  int exp_cmd[int];
  int exp_addr[int];
  bit exp_ack[int];

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; idle_edge = -1; ref_ctr = REF_INT - 1; init_clear = -1;
      ref_pend = 0; init_pend = 0; busy = 0; arm = 0; tim = '0;
    end else begin
      int trcd, twr, trp, trc, cl, c, k, p;
      busy_b = busy;
      trcd = tim[1] ? cyc(50) : cyc(25);
      twr  = tim[2] ? cyc(50) : cyc(25);
      trp  = tim[3] ? cyc(50) : cyc(25);
      trc  = tim[4] ? cyc(100) : cyc(75);
      cl   = tim[0] ? 3 : 2;
      if (n > idle_edge) begin
        if (init_pend) begin
          exp_cmd[n] = 4; exp_addr[n] = 1 << 10;
          init_pend = 0; idle_edge = n + trp; init_clear = n + trp;
        end else if (ref_pend) begin
          exp_cmd[n] = 5; exp_addr[n] = 0;
          ref_pend = 0; idle_edge = n + trc;
        end else if (req_valid) begin
          if (arm) begin
            exp_cmd[n] = 6; exp_addr[n] = int'(req_addr[13:2]);
            exp_ack[n + MRD] = 1; idle_edge = n + MRD; arm = 0;
          end else begin
            c = n + trcd; k = c + cl; p = k + (req_write ? twr : 1);
            exp_cmd[n] = 1; exp_addr[n] = int'(req_addr[21:10]);
            exp_cmd[c] = req_write ? 3 : 2; exp_addr[c] = int'(req_addr[9:2]);
            exp_ack[k] = 1;
            exp_cmd[p] = 4; exp_addr[p] = 1 << 10;
            idle_edge = p + trp;
          end
        end
      end
      if (n == init_clear) busy = 0;
      if (ref_ctr == 0) begin ref_pend = 1; ref_ctr = REF_INT - 1; end
      else ref_ctr--;
      if (cfg_we) begin
        tim = cfg_wdata[4:0];
        arm = cfg_wdata[5];
        if (cfg_wdata[6] && !busy_b) begin busy = 1; init_pend = 1; end
      end
      n++;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && n > 0) begin
      int k, ec, ea;
      string tag;
      k  = n - 1;
      ec = exp_cmd.exists(k) ? exp_cmd[k] : 0;
      ea = exp_addr.exists(k) ? exp_addr[k] : 0;
      case (ec)
        1, 2, 3: tag = "R2";
        4:       tag = "R4";
        5:       tag = "R6";
        6:       tag = "R8";
        default: tag = "R5";
      endcase
      chk(tag, "sd_cmd", int'(sd_cmd), ec);
      chk(tag, "sd_addr", int'(sd_addr), ea);
      chk("R3", "xfer_ack", int'(xfer_ack), exp_ack.exists(k) ? 1 : 0);
      chk("R9", "req_ready", int'(req_ready),
          ((n > idle_edge) && !init_pend && !ref_pend) ? 1 : 0);
      chk("R10", "cfg_rdata", int'(cfg_rdata), int'({busy, arm, tim}));
    end
  end

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [6:0] v);
    wait_ready();
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit w, input logic [ADDR_W-1:2] a);
    req_valid = 1'b1; req_write = w; req_addr = a;
    forever begin
      if (req_ready) begin @(negedge clk); break; end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "sd_cmd in reset", int'(sd_cmd), 0);
    chk("R1", "xfer_ack in reset", int'(xfer_ack), 0);
    chk("R1", "cfg_rdata in reset", int'(cfg_rdata), 0);
    chk("R1", "req_ready in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "sd_cmd after reset", int'(sd_cmd), 0);

    // Short timings, then all long, then mixed.
    cfg_write(7'h00);
    access(1'b0, 20'h12345);
    access(1'b1, 20'h0ABCD);
    cfg_write(7'h1F);
    access(1'b0, 20'hF00F3);
    access(1'b1, 20'h3C3C3);
    cfg_write(7'h05);
    access(1'b1, 20'h55AA5);
    access(1'b0, 20'hAA55A);
    cfg_write(7'h0A);
    access(1'b1, 20'h00001);
    access(1'b0, 20'hFFFFF);

    // R7: init precharge and its self-clearing flag.
    cfg_write(7'h45);
    chk("R7", "init flag set", int'(cfg_rdata[6]), 1);
    chk("R7", "ready low during init", int'(req_ready), 0);
    for (int i = 0; i < 100 && cfg_rdata[6]; i++) @(negedge clk);
    chk("R7", "init flag cleared", int'(cfg_rdata[6]), 0);
    cfg_write(7'h05);
    repeat (2) @(negedge clk);
    chk("R7", "write of 0 leaves init idle", int'(cfg_rdata[6]), 0);
    chk("R7", "no precharge from write of 0", int'(sd_cmd), 0);

    // R8: armed access becomes a mode load (burst 4 sequential, latency 3).
    cfg_write(7'h21);
    chk("R8", "arm bit set", int'(cfg_rdata[5]), 1);
    access(1'b0, 20'h00032);
    chk("R8", "arm bit cleared", int'(cfg_rdata[5]), 0);
    access(1'b0, 20'h00032);

    // R6/R9: back-to-back requests so refresh collides with traffic.
    for (int i = 0; i < 40; i++) begin
      access(i[0], 20'(i * 54321 + 99));
    end
    repeat (40) @(negedge clk);
    chk("R6", "controller idle at end", int'(req_ready), 1);
    finish_run();
  end
endmodule